// File: doc/BRIEF.md
# Clock Generator Power-State Sequencer

This block governs when a multi-output clock generator is allowed to run. From reset it walks a start-up path: it waits for the analog supply detector to report a good level, turns the PLL/VCO on, lets a programmable number of slow reference ticks elapse, and then waits for the termination-supply qualifier to go low. At that moment it captures the frequency-select and current-multiplier straps, releases every clock group and raises the global output enable.

A low level on the asynchronous power-down input is first brought into the sequencer's clock domain. It only counts as a request after it has been seen low on a fixed number of successive rising edges of the CPU complement clock. The clock groups are then stopped one after another in a fixed order, each on the first falling edge of its own clock after the previous group has stopped. The PLL/VCO enable and the output enable drop only once the last group is parked. While the CPU group is parked, its true output is held high and its complement output is released. Releasing power-down never cuts a shutdown short: the sequence always finishes and the start-up path then runs again.

Clock edges arrive as single-cycle pulses in the sequencer's clock domain, supplied by edge detectors outside this block. The supply-good flag is synchronous to the same clock.

Top module: `clkgen_pwr_seq`

## Requirements
- R1: After reset every bit of `grp_stop` is 1, and `pll_en`, `out_en`, `sel_strobe`, `sel_q` and `mult_q` are 0.
- R2: While `supply_ok` is low on the start-up path, `pll_en` and `out_en` stay 0. `ref_tick` pulses have no effect in this state.
- R3: Once `supply_ok` is seen high, `pll_en` rises. The selects are not sampled and `out_en` stays 0 until `DELAY_TICKS` pulses of `ref_tick` have been counted.
- R4: After the delay, sampling waits for `vtt_pg_n` to be low (through a two-flop synchronizer). `sel_strobe` is then high for exactly one cycle. In the following cycle `out_en` is 1 and all `grp_stop` bits are 0.
- R5: On `sel_strobe`, `sel_q[1:0]` takes `sel_lo`, `mult_q` takes `mult_in`, and `sel_q[2]` takes the tri-level code `sel_tri`: 2'b00 (low) and 2'b01 (middle) give 0, and 2'b10 or 2'b11 (high) give 1. Input changes while running do not alter the latched values.
- R6: `pd_n` passes through a two-flop synchronizer. A shutdown starts only after `QUAL_EDGES` (default 2) `cpuc_rise` pulses have been seen while it is low with no high in between. A high level restarts the count.
- R7: During shutdown the groups stop strictly in index order 0 to `NGRP-1`. Group 0 is the free-running PCI group and group 1 the buffered 66 MHz group. Group i sets `grp_stop[i]` on the first `grp_fall[i]` pulse after group i-1 has stopped. A pulse for any other group is ignored.
- R8: While the CPU group (index `NGRP-1`) is stopped, `cpu_park_hi` and `cpu_comp_off` are 1, and while it runs both are 0.
- R9: `pll_en` and `out_en` stay 1 until the last group has stopped, and fall to 0 afterwards.
- R10: If `pd_n` returns high during a shutdown, the remaining groups still stop in order. The sequencer then restarts through the supply wait, the tick delay and the qualified sampling.
- R11: After shutdown the block holds `pll_en` and `out_en` at 0 for as long as the synchronized `pd_n` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pd_n | input | 1 | Asynchronous active-low power-down request |
| supply_ok | input | 1 | Analog supply above threshold (synchronous) |
| vtt_pg_n | input | 1 | Active-low qualifier that allows the select straps to be latched (asynchronous) |
| ref_tick | input | 1 | One-cycle pulse per reference-clock period |
| cpuc_rise | input | 1 | One-cycle pulse per rising edge of the CPU complement clock |
| grp_fall | input | NGRP | One-cycle pulse per falling edge of each clock group |
| sel_lo | input | SEL_LO_W | Two-level frequency-select straps |
| sel_tri | input | 2 | Tri-level select strap code: 00 low, 01 middle, 1x high |
| mult_in | input | 1 | CPU current-multiplier strap |
| grp_stop | output | NGRP | Per-group stop request, 1 = parked low |
| cpu_park_hi | output | 1 | Hold CPU true output high |
| cpu_comp_off | output | 1 | Leave CPU complement output undriven |
| pll_en | output | 1 | PLL and VCO enable |
| sel_strobe | output | 1 | One-cycle strobe at which the straps are captured |
| out_en | output | 1 | Global output enable |
| sel_q | output | SEL_LO_W+1 | Latched frequency select, top bit from the tri-level strap |
| mult_q | output | 1 | Latched current multiplier |

## Verification
The assertions check on every cycle that groups stop only in index order and one at a time, and that the PLL never turns off while any group still runs. They also check that the output enable implies the PLL enable, that a strobe is followed by all groups released and outputs enabled, that a middle-level strap latches 0, and that the latched straps stay still while running. The bench's scenarios are needed for the rest: that the tick count, rather than the time, sets the delay, that a single edge or an interrupted low level on the power-down input starts nothing, that pulses for the wrong group are ignored, and that a release during shutdown still ends in a full stop followed by a complete restart.

// File: rtl/clkgen_pwr_pkg.sv
// Shared types for the clock generator power-state sequencer.
// Assumes nothing beyond IEEE 1800-2017 packages.
package clkgen_pwr_pkg;

    // Power states, in the order the start-up path visits them.
    typedef enum logic [2:0] {
        PS_OFF,
        PS_WAIT_SUPPLY,
        PS_DELAY,
        PS_SAMPLE,
        PS_RUN,
        PS_STOPPING,
        PS_DOWN
    } pwr_state_t;

    // Tri-level strap codes delivered by the input comparator.
    localparam logic [1:0] TRI_LOW  = 2'b00;
    localparam logic [1:0] TRI_MID  = 2'b01;
    localparam logic [1:0] TRI_HIGH = 2'b10;

    // A middle level resolves to 0; only a high level (code 1x) gives 1.
    function automatic logic tri_to_bit(input logic [1:0] code);
        return code[1];
    endfunction

endpackage

// File: rtl/clkgen_pwr_sync.sv
// Two-flop synchronizer for asynchronous level inputs.
// Assumes the input is a slow level. RST_VAL sets the value both flops take in reset.
module clkgen_pwr_sync #(
    parameter int   WIDTH   = 1,
    parameter logic RST_VAL = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] meta;

    // Two-stage capture into the clk domain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta <= {WIDTH{RST_VAL}};
            q    <= {WIDTH{RST_VAL}};
        end else begin
            meta <= d;
            q    <= meta;
        end
    end

endmodule

// File: rtl/clkgen_pwr_qual.sv
// Power-down qualifier: counts CPU complement rising-edge pulses seen while
// the synchronized request is low. It saturates at QUAL_EDGES and clears on any high.
// Assumes edge_pulse is one clk cycle wide per clock edge.
module clkgen_pwr_qual #(
    parameter int QUAL_EDGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pd_low,
    input  logic edge_pulse,
    output logic pd_req
);

    localparam int         CW    = $clog2(QUAL_EDGES + 1);
    localparam logic [CW-1:0] LIMIT = CW'(QUAL_EDGES);

    logic [CW-1:0] cnt;

    // Consecutive-edge counter, restarted by any high level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!pd_low) begin
            cnt <= '0;
        end else if (edge_pulse && cnt != LIMIT) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign pd_req = (cnt == LIMIT);

endmodule

// File: rtl/clkgen_pwr_timer.sv
// Start-up delay: counts reference ticks while run is high and clears otherwise.
// done stays high once DELAY_TICKS ticks have been counted.
// Assumes tick is one clk cycle wide.
module clkgen_pwr_timer #(
    parameter int DELAY_TICKS = 3580
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic tick,
    output logic done
);

    localparam int            CW    = $clog2(DELAY_TICKS + 1);
    localparam logic [CW-1:0] LIMIT = CW'(DELAY_TICKS);

    logic [CW-1:0] cnt;

    // Tick counter, held at zero outside the delay state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run) begin
            cnt <= '0;
        end else if (tick && cnt != LIMIT) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign done = (cnt == LIMIT);

endmodule

// File: rtl/clkgen_pwr_stopchain.sv
// Ordered group stopper: while active, parks group idx on its own falling-edge
// pulse and moves on to idx+1. clear releases every group and rearms at index 0.
// Assumes grp_fall pulses are one clk cycle wide.
module clkgen_pwr_stopchain #(
    parameter int NGRP = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            active,
    input  logic            clear,
    input  logic [NGRP-1:0] grp_fall,
    output logic [NGRP-1:0] grp_stop,
    output logic            all_stopped
);

    localparam int            IW   = $clog2(NGRP + 1);
    localparam logic [IW-1:0] LAST = IW'(NGRP);

    logic [IW-1:0]   idx;
    logic [NGRP-1:0] hit;

    // One decoder per group: only the group at the current index may stop.
    for (genvar g = 0; g < NGRP; g++) begin : g_hit
        assign hit[g] = active && (idx == IW'(g)) && grp_fall[g];
    end

    // Stop bits and sequence index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            grp_stop <= '1;
            idx      <= LAST;
        end else if (clear) begin
            grp_stop <= '0;
            idx      <= '0;
        end else if (|hit) begin
            grp_stop <= grp_stop | hit;
            idx      <= idx + 1'b1;
        end
    end

    assign all_stopped = (idx == LAST);

endmodule

// File: rtl/clkgen_pwr_sellatch.sv
// Strap latch: on capture it stores the two-level selects, the resolved
// tri-level select (middle gives 0) and the current multiplier. It holds them otherwise.
module clkgen_pwr_sellatch
    import clkgen_pwr_pkg::*;
#(
    parameter int SEL_LO_W = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                capture,
    input  logic [SEL_LO_W-1:0] sel_lo,
    input  logic [1:0]          sel_tri,
    input  logic                mult_in,
    output logic [SEL_LO_W:0]   sel_q,
    output logic                mult_q
);

    // Capture register for the strap values.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q  <= '0;
            mult_q <= 1'b0;
        end else if (capture) begin
            sel_q  <= {tri_to_bit(sel_tri), sel_lo};
            mult_q <= mult_in;
        end
    end

endmodule

// File: rtl/clkgen_pwr_seq.sv
// Power-state sequencer top. Runs the start-up path (supply wait, tick delay,
// qualified strap sampling) and the ordered shutdown on a qualified power-down
// request. Assumes edge pulses come from detectors in the clk domain and that
// supply_ok is synchronous to clk.
module clkgen_pwr_seq
    import clkgen_pwr_pkg::*;
#(
    parameter int NGRP        = 5,
    parameter int QUAL_EDGES  = 2,
    parameter int DELAY_TICKS = 3580,
    parameter int SEL_LO_W    = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                pd_n,
    input  logic                supply_ok,
    input  logic                vtt_pg_n,
    input  logic                ref_tick,
    input  logic                cpuc_rise,
    input  logic [NGRP-1:0]     grp_fall,
    input  logic [SEL_LO_W-1:0] sel_lo,
    input  logic [1:0]          sel_tri,
    input  logic                mult_in,
    output logic [NGRP-1:0]     grp_stop,
    output logic                cpu_park_hi,
    output logic                cpu_comp_off,
    output logic                pll_en,
    output logic                sel_strobe,
    output logic                out_en,
    output logic [SEL_LO_W:0]   sel_q,
    output logic                mult_q
);

    localparam int CPU_GRP = NGRP - 1;

    pwr_state_t state, state_nx;
    logic       pd_hi_s;
    logic       vtt_hi_s;
    logic       pd_req;
    logic       tmr_done;
    logic       all_stopped;

    // Power-down request synchronizer; resets as "asserted" so nothing starts early.
    clkgen_pwr_sync #(.WIDTH(1), .RST_VAL(1'b0)) u_pd_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pd_n),
        .q     (pd_hi_s)
    );

    // Termination-supply qualifier synchronizer; resets as "not ready".
    clkgen_pwr_sync #(.WIDTH(1), .RST_VAL(1'b1)) u_vtt_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (vtt_pg_n),
        .q     (vtt_hi_s)
    );

    clkgen_pwr_qual #(.QUAL_EDGES(QUAL_EDGES)) u_qual (
        .clk        (clk),
        .rst_n      (rst_n),
        .pd_low     (!pd_hi_s),
        .edge_pulse (cpuc_rise),
        .pd_req     (pd_req)
    );

    clkgen_pwr_timer #(.DELAY_TICKS(DELAY_TICKS)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (state == PS_DELAY),
        .tick  (ref_tick),
        .done  (tmr_done)
    );

    assign sel_strobe = (state == PS_SAMPLE) && !vtt_hi_s;

    clkgen_pwr_stopchain #(.NGRP(NGRP)) u_stops (
        .clk         (clk),
        .rst_n       (rst_n),
        .active      (state == PS_STOPPING),
        .clear       (sel_strobe),
        .grp_fall    (grp_fall),
        .grp_stop    (grp_stop),
        .all_stopped (all_stopped)
    );

    clkgen_pwr_sellatch #(.SEL_LO_W(SEL_LO_W)) u_latch (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (sel_strobe),
        .sel_lo  (sel_lo),
        .sel_tri (sel_tri),
        .mult_in (mult_in),
        .sel_q   (sel_q),
        .mult_q  (mult_q)
    );

    // Next-state decode for the power-state machine.
    always_comb begin
        state_nx = state;
        unique case (state)
            PS_OFF:         if (pd_hi_s)     state_nx = PS_WAIT_SUPPLY;
            PS_WAIT_SUPPLY: if (supply_ok)   state_nx = PS_DELAY;
            PS_DELAY:       if (tmr_done)    state_nx = PS_SAMPLE;
            PS_SAMPLE:      if (!vtt_hi_s)   state_nx = PS_RUN;
            PS_RUN:         if (pd_req)      state_nx = PS_STOPPING;
            PS_STOPPING:    if (all_stopped) state_nx = PS_DOWN;
            PS_DOWN:        if (pd_hi_s)     state_nx = PS_WAIT_SUPPLY;
            default:                         state_nx = PS_OFF;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= PS_OFF;
        else        state <= state_nx;
    end

    // The PLL runs from the start of the delay until after the last group stops.
    assign pll_en = (state == PS_DELAY) || (state == PS_SAMPLE) ||
                    (state == PS_RUN)   || (state == PS_STOPPING);
    assign out_en = (state == PS_RUN)   || (state == PS_STOPPING);

    // A parked CPU pair: true held high, complement released.
    assign cpu_park_hi  = grp_stop[CPU_GRP];
    assign cpu_comp_off = grp_stop[CPU_GRP];

endmodule

// File: rtl/clkgen_pwr_seq_chk.sv
// Property checker for the power-state sequencer, attached by bind.
// Observes the top-level ports only.
module clkgen_pwr_seq_chk #(
    parameter int NGRP     = 5,
    parameter int SEL_LO_W = 2
) (
    input logic                clk,
    input logic                rst_n,
    input logic [1:0]          sel_tri,
    input logic [NGRP-1:0]     grp_stop,
    input logic                pll_en,
    input logic                sel_strobe,
    input logic                out_en,
    input logic [SEL_LO_W:0]   sel_q,
    input logic                mult_q
);

    // R7: a group stops only after its predecessor has stopped.
    for (genvar g = 1; g < NGRP; g++) begin : g_ord
        p_order_r7: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(grp_stop[g]) |-> grp_stop[g-1]);
    end

    // R7: at most one group stops per cycle.
    p_one_stop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(grp_stop & ~$past(grp_stop)) <= 1);

    // R9: the PLL turns off only with every group parked.
    p_pll_last_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pll_en) |-> (&grp_stop));

    // R9: outputs are never enabled without the PLL.
    p_out_pll_r9: assert property (@(posedge clk) disable iff (!rst_n)
        out_en |-> pll_en);

    // R1: every group is parked whenever the PLL is off.
    p_idle_parked_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !pll_en |-> (&grp_stop));

    // R4: a strobe is followed by running outputs and released groups.
    p_strobe_run_r4: assert property (@(posedge clk) disable iff (!rst_n)
        sel_strobe |=> (out_en && grp_stop == '0));

    // R5: a middle-level strap latches 0.
    p_mid_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_strobe && sel_tri == 2'b01) |=> !sel_q[SEL_LO_W]);

    // R5: latched straps stay still while running.
    p_sel_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_en && $past(out_en)) |-> ($stable(sel_q) && $stable(mult_q)));

endmodule

bind clkgen_pwr_seq clkgen_pwr_seq_chk #(
    .NGRP     (NGRP),
    .SEL_LO_W (SEL_LO_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sel_tri    (sel_tri),
    .grp_stop   (grp_stop),
    .pll_en     (pll_en),
    .sel_strobe (sel_strobe),
    .out_en     (out_en),
    .sel_q      (sel_q),
    .mult_q     (mult_q)
);

// File: tb/clkgen_pwr_seq_test.sv
// Directed bench for the power-state sequencer: one task per scenario.
module clkgen_pwr_seq_test;

    localparam int NGRP  = 5;
    localparam int TICKS = 5;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            pd_n = 1'b1;
    logic            supply_ok = 1'b0;
    logic            vtt_pg_n = 1'b0;
    logic            ref_tick = 1'b0;
    logic            cpuc_rise = 1'b0;
    logic [NGRP-1:0] grp_fall = '0;
    logic [1:0]      sel_lo = 2'b00;
    logic [1:0]      sel_tri = 2'b00;
    logic            mult_in = 1'b0;
    logic [NGRP-1:0] grp_stop;
    logic            cpu_park_hi, cpu_comp_off, pll_en, sel_strobe, out_en, mult_q;
    logic [2:0]      sel_q;

    int  n_checks = 0;
    int  n_err    = 0;
    bit  done     = 1'b0;

    always #5 clk = ~clk;

    clkgen_pwr_seq #(.NGRP(NGRP), .QUAL_EDGES(2), .DELAY_TICKS(TICKS), .SEL_LO_W(2)) uut (
        .clk(clk), .rst_n(rst_n), .pd_n(pd_n), .supply_ok(supply_ok), .vtt_pg_n(vtt_pg_n),
        .ref_tick(ref_tick), .cpuc_rise(cpuc_rise), .grp_fall(grp_fall), .sel_lo(sel_lo),
        .sel_tri(sel_tri), .mult_in(mult_in), .grp_stop(grp_stop), .cpu_park_hi(cpu_park_hi),
        .cpu_comp_off(cpu_comp_off), .pll_en(pll_en), .sel_strobe(sel_strobe),
        .out_en(out_en), .sel_q(sel_q), .mult_q(mult_q)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_tick();
        ref_tick = 1'b1; step(1); ref_tick = 1'b0; step(2);
    endtask

    task automatic pulse_cpuc();
        cpuc_rise = 1'b1; step(1); cpuc_rise = 1'b0; step(3);
    endtask

    task automatic pulse_fall(input int g);
        grp_fall[g] = 1'b1; step(1); grp_fall = '0; step(2);
    endtask

    // Wait for out_en, counting strobes on the way.
    task automatic wait_run(input int maxc, output int strobes);
        strobes = 0;
        for (int i = 0; i < maxc && !out_en; i++) begin
            step(1);
            if (sel_strobe) strobes++;
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0; step(4);
        chk("R1 grp_stop in reset", grp_stop, 5'b11111);
        chk("R1 pll_en in reset", pll_en, 0);
        chk("R1 out_en in reset", out_en, 0);
        chk("R1 sel_q/mult_q in reset", {sel_q, mult_q}, 0);
        rst_n = 1'b1; step(1);
        chk("R1 sel_strobe after reset", sel_strobe, 0);
    endtask

    task automatic t_startup();
        int s;
        sel_lo = 2'b10; sel_tri = 2'b01; mult_in = 1'b1; vtt_pg_n = 1'b0;
        step(6);
        for (int i = 0; i < 6; i++) pulse_tick();
        chk("R2 pll_en while supply low", pll_en, 0);
        chk("R2 out_en while supply low", out_en, 0);
        supply_ok = 1'b1; step(3);
        chk("R3 pll_en after supply good", pll_en, 1);
        for (int i = 0; i < TICKS - 1; i++) pulse_tick();
        step(3);
        chk("R3 out_en before last tick", out_en, 0);
        ref_tick = 1'b1; step(1); ref_tick = 1'b0;
        wait_run(10, s);
        chk("R3 out_en after full delay", out_en, 1);
        chk("R4 single strobe", s, 1);
        chk("R4 groups released", grp_stop, 0);
        chk("R5 mid strap latches 0", sel_q, 3'b010);
        chk("R5 mult latched", mult_q, 1);
        chk("R8 cpu pair running", {cpu_park_hi, cpu_comp_off}, 0);
        sel_lo = 2'b01; sel_tri = 2'b10; mult_in = 1'b0; step(6);
        chk("R5 straps ignored while running", {sel_q, mult_q}, 4'b0101);
    endtask

    task automatic t_qualify();
        pd_n = 1'b0; step(4);
        pulse_cpuc();
        pulse_fall(0);
        chk("R6 one edge does not qualify", grp_stop, 0);
        pd_n = 1'b1; step(5);
        pd_n = 1'b0; step(4);
        pulse_cpuc();
        pulse_fall(0);
        chk("R6 high level restarts count", grp_stop, 0);
        chk("R6 outputs still enabled", out_en, 1);
        pulse_cpuc();
    endtask

    task automatic t_order();
        pulse_fall(2);
        chk("R7 out-of-order pulse ignored", grp_stop, 0);
        pulse_fall(0);
        chk("R7 first group PCI free-run", grp_stop, 5'b00001);
        pulse_fall(0);
        pulse_fall(1);
        chk("R7 second group 66M buffered", grp_stop, 5'b00011);
        pulse_fall(2);
        pulse_fall(3);
        chk("R7 groups 2,3 in order", grp_stop, 5'b01111);
        chk("R9 pll on before last group", pll_en, 1);
        chk("R9 out_en on before last group", out_en, 1);
        chk("R8 cpu pair not yet parked", {cpu_park_hi, cpu_comp_off}, 0);
        pulse_fall(4);
        chk("R7 all groups parked", grp_stop, 5'b11111);
        chk("R8 cpu parked high, complement off", {cpu_park_hi, cpu_comp_off}, 2'b11);
        chk("R9 pll off after last group", pll_en, 0);
        chk("R9 out_en off after last group", out_en, 0);
        step(20);
        chk("R11 held down while pd_n low", {pll_en, out_en}, 0);
    endtask

    task automatic t_restart_vtt();
        int s;
        vtt_pg_n = 1'b1; sel_lo = 2'b01; sel_tri = 2'b10; mult_in = 1'b0;
        pd_n = 1'b1; step(6);
        chk("R11 leaves down state on release", pll_en, 1);
        for (int i = 0; i < TICKS; i++) pulse_tick();
        step(10);
        chk("R4 waits for vtt qualifier", out_en, 0);
        chk("R4 no strobe without qualifier", sel_strobe, 0);
        vtt_pg_n = 1'b0;
        wait_run(10, s);
        chk("R4 runs after qualifier", out_en, 1);
        chk("R4 strobe once after qualifier", s, 1);
        chk("R5 high strap latches 1", {sel_q, mult_q}, 4'b1010);
    endtask

    task automatic t_release_midway();
        int s;
        sel_tri = 2'b11;
        pd_n = 1'b0; step(4);
        pulse_cpuc(); pulse_cpuc();
        pulse_fall(0);
        pd_n = 1'b1; step(8);
        chk("R10 sequence continues after release", grp_stop, 5'b00001);
        chk("R10 outputs still enabled mid-sequence", out_en, 1);
        pulse_fall(1); pulse_fall(2); pulse_fall(3);
        supply_ok = 1'b0;
        pulse_fall(4);
        step(4);
        chk("R10 full stop before restart", grp_stop, 5'b11111);
        chk("R10 restart waits for supply", {pll_en, out_en}, 0);
        supply_ok = 1'b1; step(3);
        for (int i = 0; i < TICKS; i++) pulse_tick();
        wait_run(10, s);
        chk("R10 restarted", out_en, 1);
        chk("R5 code 11 latches 1", sel_q[2], 1);
    endtask

    initial begin
        t_reset();
        t_startup();
        t_qualify();
        t_order();
        t_restart_vtt();
        t_release_midway();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
            $finish;
        end
    end

endmodule